// File: doc/BRIEF.md
# DRAM refresh and initialization sequencer

This block owns every DRAM cycle that is not a data access. After reset it keeps the memory untouched for the power-up pause. It then runs a burst of initialization refreshes and raises `init_done`. From then on it issues one refresh per refresh interval. The interval is derived from the clock frequency, the refresh period and the number of rows, so that every row is refreshed within the period.

The block shares the DRAM strobes with an access controller. When it wants a cycle it raises `ref_req`. It drives RAS and CAS low only while `ref_grant` is high. It keeps `ref_req` high until the precharge of its cycle has ended. Interval ticks that arrive while the grant is withheld are held in a saturating backlog of up to eight owed refreshes. A full backlog raises `ref_urgent`, so that the access controller can cut its burst short.

Two refresh kinds are selectable. CAS-before-RAS uses the row counter inside the DRAM. RAS-only drives the block's own row counter onto a row address bus during the strobe.

Top module: `dram_refresh_seq`

## Requirements
- R1: While reset is asserted and directly after it, `ras_n`, `cas_n` and `we_n` are 1, and `ref_req`, `ref_own`, `ref_urgent`, `init_done` and `addr_en` are 0.
- R2: `ref_req` stays 0 for the first CLK_MHZ*PAUSE_US cycles after reset, and rises within two cycles after that pause ends.
- R3: After the pause, exactly INIT_CYCLES (8) refresh cycles run. `init_done` is 0 while they run, rises once the last one has finished, and then stays 1.
- R4: In a CAS-before-RAS refresh (`ras_only_mode`=0 when the grant is taken), `cas_n` falls T_CSR_CYC cycles before `ras_n` falls and stays 0 for the whole RAS-low time. `we_n` is 1 throughout.
- R5: `ras_n` is low for exactly T_RAS_CYC cycles per refresh. Between two refreshes `ras_n` is high for at least T_RP_CYC cycles.
- R6: After initialization, one refresh is owed every floor(CLK_MHZ*REF_PERIOD_MS*1000/REF_ROWS) cycles. With an immediate grant, successive RAS falls are exactly that many cycles apart.
- R7: Each interval tick adds one owed refresh and each completed refresh after initialization removes one. The count saturates at BACKLOG_MAX (8). `ref_urgent` is 1 exactly when the count is at that limit, and `ref_req` stays high while refreshes are owed.
- R8: While `ref_grant` is 0, `ras_n` and `cas_n` stay 1 and `ref_own` is 0. Once `ref_req` has risen, it stays high until the precharge of that cycle has ended.
- R9: In a RAS-only refresh (`ras_only_mode`=1 when the grant is taken), `cas_n` stays 1. `addr_en` is 1 and `row_addr` carries the row counter one cycle before RAS falls and while RAS is low. The counter advances by one after each RAS-only refresh.
- R10: The row counter wraps from 2^ROW_BITS-1 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ras_only_mode | input | 1 | 1 selects RAS-only refresh, 0 selects CAS-before-RAS; sampled when the grant is taken |
| ref_grant | input | 1 | Strobe ownership granted by the access controller |
| ref_req | output | 1 | Request for the DRAM strobes |
| ref_urgent | output | 1 | Backlog of owed refreshes is full |
| init_done | output | 1 | Power-up pause and initialization burst are complete |
| ref_own | output | 1 | Block is driving the strobes this cycle |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, held high during refresh |
| addr_en | output | 1 | Row address valid on `row_addr` |
| row_addr | output | ROW_BITS | Row address for RAS-only refresh |

## Verification
The first request is due one cycle after the pause counter expires, and the bench samples `ref_req` two cycles before and a few cycles after that point. In each refresh, CAS falls T_CSR_CYC cycles before RAS and RAS stays low T_RAS_CYC cycles. A monitor samples on the falling clock edge and counts low and high cycles of the strobes, so edge ordering never decides a result. Refresh spacing is measured as the difference of RAS-fall cycle numbers and must equal the interval the bench computes itself. Backlog and urgent states are sampled at whole-interval offsets from the start of a grant hold-off, with margins of more than one interval. A queue of expected row addresses is compared at every RAS-only fall.

// File: rtl/dram_ref_pkg.sv
package dram_ref_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_SETUP,
    ST_ACTIVE,
    ST_PRE
  } seq_state_e;

  // cycles in the power-up pause
  function automatic int unsigned pause_cycles(input int unsigned clk_mhz,
                                               input int unsigned pause_us);
    return clk_mhz * pause_us;
  endfunction

  // cycles between refresh ticks: the whole period spread over all rows
  function automatic int unsigned interval_cycles(input int unsigned clk_mhz,
                                                  input int unsigned period_ms,
                                                  input int unsigned rows);
    return (clk_mhz * period_ms * 1000) / rows;
  endfunction

  function automatic int unsigned max3(input int unsigned a,
                                       input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/dram_ref_timer.sv
module dram_ref_timer #(
  parameter int unsigned PAUSE_CYC    = 25000,
  parameter int unsigned INTERVAL_CYC = 1953
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic pause_done,
  output logic tick
);
  localparam int PW = $clog2(PAUSE_CYC + 1);
  localparam int IW = $clog2(INTERVAL_CYC + 1);
  localparam logic [PW-1:0] PAUSE_LAST = PW'(PAUSE_CYC - 1);
  localparam logic [IW-1:0] IVL_LAST   = IW'(INTERVAL_CYC - 1);

  logic [PW-1:0] pause_cnt;
  logic [IW-1:0] ivl_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pause_cnt  <= '0;
      pause_done <= 1'b0;
    end else if (!pause_done) begin
      if (pause_cnt == PAUSE_LAST) pause_done <= 1'b1;
      else                         pause_cnt  <= pause_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     ivl_cnt <= '0;
    else if (run)   ivl_cnt <= (ivl_cnt == IVL_LAST) ? '0 : ivl_cnt + 1'b1;
  end

  assign tick = run && (ivl_cnt == IVL_LAST);

  // R6: ticks never come back to back
  assert_tick_spacing_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

  // R2: once the pause is over it is over for good
  assert_pause_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pause_done |=> pause_done);

endmodule

// File: rtl/dram_ref_backlog.sv
module dram_ref_backlog #(
  parameter int unsigned BACKLOG_MAX = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic served,
  output logic owed_nz,
  output logic urgent
);
  localparam int BW = $clog2(BACKLOG_MAX + 1);
  localparam logic [BW-1:0] LIMIT = BW'(BACKLOG_MAX);

  logic [BW-1:0] owed;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      owed <= '0;
    end else begin
      case ({tick, served})
        2'b10:   if (owed != LIMIT) owed <= owed + 1'b1;
        2'b01:   if (owed != '0)    owed <= owed - 1'b1;
        default: owed <= owed;
      endcase
    end
  end

  assign owed_nz = (owed != '0);
  assign urgent  = (owed == LIMIT);

  // R7: the count never exceeds its limit
  assert_backlog_cap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    owed <= LIMIT);

  // R7: a completed refresh always retires an owed one
  assert_served_has_debt_R7: assert property (@(posedge clk) disable iff (!rst_n)
    served |-> owed_nz);

  // R7: a tick on a full backlog keeps it full
  assert_backlog_sat_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (urgent && tick && !served) |=> urgent);

endmodule

// File: rtl/dram_ref_fsm.sv
module dram_ref_fsm
  import dram_ref_pkg::*;
#(
  parameter int unsigned T_CSR_CYC = 1,
  parameter int unsigned T_RAS_CYC = 8,
  parameter int unsigned T_RP_CYC  = 5,
  parameter int unsigned ROW_BITS  = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                need,
  input  logic                ras_only_mode,
  input  logic                ref_grant,
  output logic                ref_req,
  output logic                ref_own,
  output logic                ras_n,
  output logic                cas_n,
  output logic                we_n,
  output logic                addr_en,
  output logic [ROW_BITS-1:0] row_addr,
  output logic                cyc_done
);
  localparam int unsigned TMAX = max3(T_CSR_CYC, T_RAS_CYC, T_RP_CYC);
  localparam int CW = $clog2(TMAX + 1);
  localparam logic [CW-1:0] CSR_LOAD = CW'(T_CSR_CYC - 1);
  localparam logic [CW-1:0] RAS_LOAD = CW'(T_RAS_CYC - 1);
  localparam logic [CW-1:0] RP_LOAD  = CW'(T_RP_CYC - 1);

  seq_state_e          state;
  logic [CW-1:0]       cnt;
  logic                cyc_ro;
  logic [ROW_BITS-1:0] row_q;
  logic                cnt_zero;
  logic                in_setup, in_active, in_pre, busy, strobe_win;

  assign cnt_zero  = (cnt == '0);
  assign in_setup  = (state == ST_SETUP);
  assign in_active = (state == ST_ACTIVE);
  assign in_pre    = (state == ST_PRE);
  assign busy      = in_setup || in_active || in_pre;
  assign strobe_win = in_setup || in_active;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      cyc_ro <= 1'b0;
    end else begin
      case (state)
        ST_IDLE:   if (need) state <= ST_WAIT;
        ST_WAIT:   if (ref_grant) begin
                     state  <= ST_SETUP;
                     cnt    <= CSR_LOAD;
                     cyc_ro <= ras_only_mode;
                   end
        ST_SETUP:  if (cnt_zero) begin
                     state <= ST_ACTIVE;
                     cnt   <= RAS_LOAD;
                   end else cnt <= cnt - 1'b1;
        ST_ACTIVE: if (cnt_zero) begin
                     state <= ST_PRE;
                     cnt   <= RP_LOAD;
                   end else cnt <= cnt - 1'b1;
        ST_PRE:    if (cnt_zero) state <= ST_IDLE;
                   else          cnt   <= cnt - 1'b1;
        default:   state <= ST_IDLE;
      endcase
    end
  end

  assign cyc_done = in_pre && cnt_zero;

  // row counter for RAS-only refresh, wraps naturally
  always_ff @(posedge clk) begin
    if (!rst_n)                 row_q <= '0;
    else if (cyc_done && cyc_ro) row_q <= row_q + 1'b1;
  end

  assign ref_req  = (state != ST_IDLE);
  assign ref_own  = busy && ref_grant;
  assign ras_n    = !(ref_own && in_active);
  assign cas_n    = !(ref_own && !cyc_ro && strobe_win);
  assign we_n     = 1'b1;
  assign addr_en  = ref_own && cyc_ro && strobe_win;
  assign row_addr = addr_en ? row_q : '0;

  // R8: no strobe is driven low without the grant
  assert_strobes_need_grant_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_grant |-> (ras_n && cas_n));

  // R8: the request is held until the precharge ends
  assert_req_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_req && !cyc_done) |=> ref_req);

  // R4: CAS was already low in the cycle before RAS fell
  assert_cbr_setup_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ras_n) && !cas_n) |-> $past(!cas_n));

  // R4: CAS stays low past the RAS fall
  assert_cbr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ras_n) && !cas_n) |=> !cas_n);

  // R9: a RAS-only cycle never pulls CAS
  assert_rasonly_cas_R9: assert property (@(posedge clk) disable iff (!rst_n)
    addr_en |-> cas_n);

  // R9: the row address holds while it is valid
  assert_addr_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_en && $past(addr_en)) |-> $stable(row_addr));

endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq
  import dram_ref_pkg::*;
#(
  parameter int unsigned CLK_MHZ       = 125,
  parameter int unsigned PAUSE_US      = 200,
  parameter int unsigned REF_ROWS      = 4096,
  parameter int unsigned REF_PERIOD_MS = 64,
  parameter int unsigned INIT_CYCLES   = 8,
  parameter int unsigned BACKLOG_MAX   = 8,
  parameter int unsigned ROW_BITS      = 12,
  parameter int unsigned T_CSR_CYC     = 1,
  parameter int unsigned T_RAS_CYC     = 8,
  parameter int unsigned T_RP_CYC      = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ras_only_mode,
  input  logic                ref_grant,
  output logic                ref_req,
  output logic                ref_urgent,
  output logic                init_done,
  output logic                ref_own,
  output logic                ras_n,
  output logic                cas_n,
  output logic                we_n,
  output logic                addr_en,
  output logic [ROW_BITS-1:0] row_addr
);
  localparam int unsigned PAUSE_CYC    = pause_cycles(CLK_MHZ, PAUSE_US);
  localparam int unsigned INTERVAL_CYC = interval_cycles(CLK_MHZ, REF_PERIOD_MS, REF_ROWS);
  localparam int NW = $clog2(INIT_CYCLES + 1);
  localparam logic [NW-1:0] INIT_LAST = NW'(INIT_CYCLES);

  logic          pause_done, tick, owed_nz, cyc_done, need, served;
  logic [NW-1:0] init_cnt;

  dram_ref_timer #(
    .PAUSE_CYC    (PAUSE_CYC),
    .INTERVAL_CYC (INTERVAL_CYC)
  ) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (init_done),
    .pause_done (pause_done),
    .tick       (tick)
  );

  assign served = cyc_done && init_done;

  dram_ref_backlog #(
    .BACKLOG_MAX (BACKLOG_MAX)
  ) u_backlog (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .served  (served),
    .owed_nz (owed_nz),
    .urgent  (ref_urgent)
  );

  // initialization burst counter
  always_ff @(posedge clk) begin
    if (!rst_n)                    init_cnt <= '0;
    else if (cyc_done && !init_done) init_cnt <= init_cnt + 1'b1;
  end

  assign init_done = (init_cnt == INIT_LAST);
  assign need      = pause_done && (!init_done || owed_nz);

  dram_ref_fsm #(
    .T_CSR_CYC (T_CSR_CYC),
    .T_RAS_CYC (T_RAS_CYC),
    .T_RP_CYC  (T_RP_CYC),
    .ROW_BITS  (ROW_BITS)
  ) u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .need          (need),
    .ras_only_mode (ras_only_mode),
    .ref_grant     (ref_grant),
    .ref_req       (ref_req),
    .ref_own       (ref_own),
    .ras_n         (ras_n),
    .cas_n         (cas_n),
    .we_n          (we_n),
    .addr_en       (addr_en),
    .row_addr      (row_addr),
    .cyc_done      (cyc_done)
  );

  // R2: the DRAM is left alone until the pause has run out
  assert_quiet_pause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !pause_done |-> (!ref_req && ras_n && cas_n));

  // R3: initialization completes once and stays complete
  assert_init_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);

  // R3: no interval tick is counted during initialization
  assert_no_tick_in_init_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !init_done |-> !tick);

endmodule

// File: tb/dram_refresh_seq_test.sv
module dram_refresh_seq_test;
  localparam int unsigned CLK_MHZ  = 125;
  localparam int unsigned PAUSE_US = 2;
  localparam int unsigned ROWS     = 4096;
  localparam int unsigned PER_MS   = 2;
  localparam int unsigned RBITS    = 4;
  localparam int unsigned T_CSR    = 1;
  localparam int unsigned T_RAS    = 8;
  localparam int unsigned T_RP     = 5;
  localparam int unsigned N_INIT   = 8;
  // expected values derived in nanoseconds with an 8 ns period
  localparam int PAUSE_EXP = (PAUSE_US * 1000) / 8;
  localparam int IVL_EXP   = ((PER_MS * 1000000) / ROWS) / 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic             rst_n = 1'b0;
  logic             ras_only_mode = 1'b0;
  logic             ref_grant = 1'b0;
  logic             ref_req, ref_urgent, init_done, ref_own;
  logic             ras_n, cas_n, we_n, addr_en;
  logic [RBITS-1:0] row_addr;

  dram_refresh_seq #(
    .CLK_MHZ (CLK_MHZ), .PAUSE_US (PAUSE_US), .REF_ROWS (ROWS),
    .REF_PERIOD_MS (PER_MS), .INIT_CYCLES (N_INIT), .BACKLOG_MAX (8),
    .ROW_BITS (RBITS), .T_CSR_CYC (T_CSR), .T_RAS_CYC (T_RAS), .T_RP_CYC (T_RP)
  ) uut (
    .clk (clk), .rst_n (rst_n), .ras_only_mode (ras_only_mode),
    .ref_grant (ref_grant), .ref_req (ref_req), .ref_urgent (ref_urgent),
    .init_done (init_done), .ref_own (ref_own), .ras_n (ras_n), .cas_n (cas_n),
    .we_n (we_n), .addr_en (addr_en), .row_addr (row_addr)
  );

  int     checks = 0;
  int     fails  = 0;
  longint cyc    = 0;
  int     nfall  = 0;
  longint fall_cyc = 0;
  longint first_fall = -1;
  bit     hold_off = 1'b0;
  bit     mode_exp = 1'b0;
  int     exp_rows[$];

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // access controller model: grants at the falling edge unless held off
  always @(negedge clk) begin
    if (!rst_n) ref_grant <= 1'b0;
    else        ref_grant <= ref_req && !hold_off;
  end

  // monitor: scoreboard pop and strobe timing
  logic   p_ras = 1'b1, p_cas = 1'b1, p_aen = 1'b0;
  logic [RBITS-1:0] p_addr = '0;
  int     low_cnt = 0, cas_low_cnt = 0, high_cnt = 0;
  bit     high_seen = 1'b0, cur_ro = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (p_ras && !ras_n) begin
        nfall++;
        fall_cyc = cyc;
        if (first_fall < 0) first_fall = cyc;
        check(we_n == 1'b1, "R4 we_n at RAS fall", we_n, 1);
        if (nfall <= N_INIT) check(!init_done, "R3 init_done before burst end", init_done, 0);
        if (high_seen) check(high_cnt >= T_RP, "R5 precharge length", high_cnt, T_RP);
        low_cnt = 1;
        cas_low_cnt = cas_n ? 0 : 1;
        cur_ro = mode_exp;
        if (!mode_exp) begin
          check(!cas_n && !p_cas, "R4 CAS low before RAS", {p_cas, cas_n}, 0);
        end else begin
          check(cas_n, "R9 CAS high in RAS-only", cas_n, 1);
          if (exp_rows.size() == 0) begin
            check(1'b0, "R9 unexpected RAS-only cycle", row_addr, -1);
          end else begin
            int e;
            e = exp_rows.pop_front();
            check(addr_en && p_aen && int'(row_addr) == e && int'(p_addr) == e,
                  "R10 row address", row_addr, e);
          end
        end
      end else if (!ras_n) begin
        low_cnt++;
        if (!cas_n) cas_low_cnt++;
      end else if (!p_ras && ras_n) begin
        check(low_cnt == T_RAS, "R5 RAS low width", low_cnt, T_RAS);
        check(cas_low_cnt == (cur_ro ? 0 : T_RAS), "R4 CAS held through RAS low",
              cas_low_cnt, cur_ro ? 0 : T_RAS);
        high_cnt = 1;
        high_seen = 1'b1;
      end else begin
        high_cnt++;
      end
      p_ras  = ras_n;
      p_cas  = cas_n;
      p_aen  = addr_en;
      p_addr = row_addr;
    end
  end

  task automatic wait_req_low();
    @(negedge clk);
    while (ref_req) @(negedge clk);
  endtask

  initial begin
    longint t1, t2, t3;
    int n0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(ras_n && cas_n && we_n, "R1 strobes idle in reset", {ras_n, cas_n, we_n}, 7);
    check(!ref_req && !ref_own && !addr_en, "R1 request idle in reset", {ref_req, ref_own, addr_en}, 0);
    check(!init_done && !ref_urgent, "R1 status low in reset", {init_done, ref_urgent}, 0);
    rst_n = 1'b1;

    // pause
    repeat (PAUSE_EXP - 2) @(posedge clk);
    @(negedge clk);
    check(!ref_req, "R2 no request during pause", ref_req, 0);
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(ref_req, "R2 request after pause", ref_req, 1);

    // initialization burst
    while (!init_done) @(negedge clk);
    check(nfall == N_INIT, "R3 init cycle count", nfall, N_INIT);
    check(first_fall >= PAUSE_EXP, "R2 first RAS after pause", first_fall, PAUSE_EXP);

    // steady interval
    n0 = nfall;
    while (nfall < n0 + 1) @(negedge clk);
    t1 = fall_cyc;
    while (nfall < n0 + 2) @(negedge clk);
    t2 = fall_cyc;
    while (nfall < n0 + 3) @(negedge clk);
    t3 = fall_cyc;
    check(t2 - t1 == IVL_EXP, "R6 refresh spacing", t2 - t1, IVL_EXP);
    check(t3 - t2 == IVL_EXP, "R6 refresh spacing", t3 - t2, IVL_EXP);
    check(init_done, "R3 init_done stays high", init_done, 1);

    // backlog while grant is withheld
    wait_req_low();
    @(posedge clk) #1 hold_off = 1'b1;
    n0 = nfall;
    repeat (6 * IVL_EXP) @(posedge clk);
    @(negedge clk);
    check(!ref_urgent, "R7 not urgent after six intervals", ref_urgent, 0);
    check(ref_req, "R7 request pending with backlog", ref_req, 1);
    check(ras_n && cas_n && !ref_own, "R8 strobes idle without grant", {ras_n, cas_n, ref_own}, 6);
    repeat (3 * IVL_EXP) @(posedge clk);
    @(negedge clk);
    check(ref_urgent, "R7 urgent after nine intervals", ref_urgent, 1);
    check(nfall == n0, "R8 no refresh without grant", nfall, n0);
    @(posedge clk) #1 hold_off = 1'b0;
    n0 = nfall;
    while (nfall < n0 + 2) @(negedge clk);
    wait_req_low();
    check(!ref_urgent, "R7 saturated backlog drains", ref_urgent, 0);

    // drain fully, then RAS-only with wrap
    begin
      int quiet = 0;
      while (quiet < 40) begin
        @(negedge clk);
        quiet = ref_req ? 0 : quiet + 1;
      end
    end
    @(posedge clk) #1;
    ras_only_mode = 1'b1;
    mode_exp = 1'b1;
    for (int i = 0; i < 18; i++) exp_rows.push_back(i % (1 << RBITS));
    while (exp_rows.size() != 0) @(negedge clk);
    wait_req_low();
    @(posedge clk) #1;
    ras_only_mode = 1'b0;
    mode_exp = 1'b0;
    n0 = nfall;
    while (nfall < n0 + 1) @(negedge clk);
    repeat (T_RAS + 4) @(negedge clk);
    check(init_done && !addr_en, "R9 back to CAS-before-RAS", {init_done, addr_en}, 2);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 20000);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule